// File: doc/BRIEF.md
# Rate-Half Four-State Convolutional Encoder

This block turns a serial stream of data bits into two-bit coded symbols. Each symbol comes from a four-state, constraint-length-three convolutional code. The encoder remembers the two most recent accepted bits. For each new bit it forms one parity bit from the new bit and both remembered bits (polynomial 1+D+D²). It forms a second parity bit from the new bit and the older remembered bit (polynomial 1+D²). The resulting symbol is registered and appears one clock later with a valid flag.

The two remembered bits are exposed as the encoder state, so a trellis decoder bench can follow transitions. In the state, the newest bit sits in the MSB and the older bit sits in the LSB. A start strobe clears the memory so that a new block begins from the all-zero state. Input bits are accepted only on cycles where the input-valid strobe is high.

Top module: `conv_enc_r2`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets enc_state to 2'b00, sym_out to 2'b00 and sym_vld to 0.
- R2: For an accepted bit, sym_out[1] becomes in_bit XOR enc_state[1] XOR enc_state[0], using the state before that bit.
- R3: For an accepted bit, sym_out[0] becomes in_bit XOR enc_state[0], using the state before that bit.
- R4: An accepted bit updates the state by a right shift. The new bit becomes enc_state[1], and the old enc_state[1] becomes enc_state[0].
- R5: From state 00, bit 0 keeps state 00 and emits symbol 00, while bit 1 moves to state 10 and emits symbol 11.
- R6: Starting from state 00, the bits 1,0,0,1,1 produce the symbols 11,10,11,11,01 in that order.
- R7: sym_vld equals the value in_vld had one clock earlier.
- R8: While in_vld is low and start is low, enc_state and sym_out keep their values.
- R9: start high clears the memory. With in_vld low, the state becomes 00 and sym_out holds. With in_vld high in the same cycle, that bit is encoded from state 00 and the state becomes {in_bit, 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears the encoder memory; begins a new block |
| in_vld | input | 1 | Data bit valid strobe |
| in_bit | input | 1 | Serial data bit |
| sym_out | output | 2 | Registered symbol {1+D+D² bit, 1+D² bit} |
| sym_vld | output | 1 | Symbol valid, in_vld delayed one clock |
| enc_state | output | 2 | Encoder memory {previous bit, bit before that} |

## Verification
A wrong memory bit shows up on enc_state at the edge that accepts the next bit. It also corrupts sym_out one clock after the following accepted bit, because both parity bits depend on it. A swapped shift order affects only the 1+D² lane, and only when two consecutive bits differ. For that reason, long alternating patterns and the fixed reference sequence are checked symbol by symbol. Start and hold behaviour are checked by reading enc_state on the cycle right after the strobe and comparing it with the value before.

// File: rtl/conv_enc_r2.sv
module conv_enc_r2 (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       in_vld,
  input  logic       in_bit,
  output logic [1:0] sym_out,
  output logic       sym_vld,
  output logic [1:0] enc_state
);

  logic [1:0] mem;
  logic [1:0] base;
  logic       p_full;
  logic       p_skip;

  assign base   = start ? 2'b00 : mem;
  assign p_full = in_bit ^ base[1] ^ base[0];
  assign p_skip = in_bit ^ base[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem     <= 2'b00;
      sym_out <= 2'b00;
      sym_vld <= 1'b0;
    end else begin
      sym_vld <= in_vld;
      if (in_vld) begin
        mem     <= {in_bit, base[1]};
        sym_out <= {p_full, p_skip};
      end else if (start) begin
        mem <= 2'b00;
      end
    end
  end

  assign enc_state = mem;

endmodule

// File: rtl/conv_enc_r2_chk.sv
module conv_enc_r2_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       in_vld,
  input logic       in_bit,
  input logic [1:0] sym_out,
  input logic       sym_vld,
  input logic [1:0] enc_state
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (enc_state == 2'b00 && sym_out == 2'b00 && !sym_vld));

  assert_upper_parity_R2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !start) |=> sym_out[1] == ($past(in_bit) ^ $past(enc_state[1]) ^ $past(enc_state[0])));

  assert_lower_parity_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !start) |=> sym_out[0] == ($past(in_bit) ^ $past(enc_state[0])));

  assert_shift_right_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !start) |=> enc_state == {$past(in_bit), $past(enc_state[1])});

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> sym_vld);

  assert_valid_low_R7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !sym_vld);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !start) |=> ($stable(enc_state) && $stable(sym_out)));

  assert_start_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !in_vld) |=> (enc_state == 2'b00 && $stable(sym_out)));

  assert_start_encode_R9: assert property (@(posedge clk) disable iff (rst)
    (start && in_vld) |=> (enc_state == {$past(in_bit), 1'b0} && sym_out == {2{$past(in_bit)}}));

endmodule

bind conv_enc_r2 conv_enc_r2_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .in_vld(in_vld), .in_bit(in_bit),
  .sym_out(sym_out), .sym_vld(sym_vld), .enc_state(enc_state)
);

// File: tb/sim_conv_enc_r2.sv
module sim_conv_enc_r2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       in_vld = 1'b0;
  logic       in_bit = 1'b0;
  logic [1:0] sym_out;
  logic       sym_vld;
  logic [1:0] enc_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] ref_st = 2'b00;
  logic [1:0] ref_sym = 2'b00;

  always #4 clk = ~clk;

  conv_enc_r2 u0 (
    .clk(clk), .rst(rst), .start(start), .in_vld(in_vld), .in_bit(in_bit),
    .sym_out(sym_out), .sym_vld(sym_vld), .enc_state(enc_state)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic b, input logic s);
    logic [1:0] base;
    in_vld = v; in_bit = b; start = s;
    base = s ? 2'b00 : ref_st;
    if (v) begin
      ref_sym = {b ^ base[1] ^ base[0], b ^ base[0]};
      ref_st  = {b, base[1]};
    end else if (s) begin
      ref_st = 2'b00;
    end
    @(posedge clk); #1;
    in_vld = 1'b0; start = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R1 state", enc_state, 2'b00);
    chk("R1 symbol", sym_out, 2'b00);
    chk("R1 valid", {1'b0, sym_vld}, 2'b00);
    rst = 1'b0;
    ref_st = 2'b00; ref_sym = 2'b00;
  endtask

  task automatic t_from_zero;
    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R5 zero-in state", enc_state, 2'b00);
    chk("R5 zero-in symbol", sym_out, 2'b00);
    cyc(1'b1, 1'b1, 1'b0);
    chk("R5 one-in state", enc_state, 2'b10);
    chk("R5 one-in symbol", sym_out, 2'b11);
  endtask

  task automatic t_sequence;
    logic [4:0] bits = 5'b10011;
    logic [1:0] want [5] = '{2'b11, 2'b10, 2'b11, 2'b11, 2'b01};
    cyc(1'b0, 1'b0, 1'b1);
    chk("R9 start clears", enc_state, 2'b00);
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, bits[4-i], 1'b0);
      chk("R6 sequence symbol", sym_out, want[i]);
      chk("R7 valid high", {1'b0, sym_vld}, 2'b01);
    end
  endtask

  task automatic t_pattern;
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 60; i++) begin
      cyc(1'b1, lfsr[0], 1'b0);
      chk("R2 upper parity", {1'b0, sym_out[1]}, {1'b0, ref_sym[1]});
      chk("R3 lower parity", {1'b0, sym_out[0]}, {1'b0, ref_sym[0]});
      chk("R4 shift", enc_state, ref_st);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, i[0], 1'b0);
      chk("R2 R3 alternating symbol", sym_out, ref_sym);
      chk("R4 alternating state", enc_state, ref_st);
    end
  endtask

  task automatic t_hold;
    logic [1:0] st0, sy0;
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    st0 = enc_state; sy0 = sym_out;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, i[0], 1'b0);
      chk("R8 state hold", enc_state, st0);
      chk("R8 symbol hold", sym_out, sy0);
      chk("R7 valid low", {1'b0, sym_vld}, 2'b00);
    end
  endtask

  task automatic t_start;
    logic [1:0] sy0;
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    chk("R4 state before start", enc_state, 2'b11);
    sy0 = sym_out;
    cyc(1'b0, 1'b1, 1'b1);
    chk("R9 start state", enc_state, 2'b00);
    chk("R9 start symbol hold", sym_out, sy0);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R9 start with bit state", enc_state, 2'b10);
    chk("R9 start with bit symbol", sym_out, 2'b11);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R9 start with zero state", enc_state, 2'b00);
    chk("R9 start with zero symbol", sym_out, 2'b00);
  endtask

  initial begin
    t_reset();
    t_from_zero();
    t_sequence();
    t_pattern();
    t_hold();
    t_start();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule